// File: doc/BRIEF.md
# Delay-Aligned Bit Error Meter

This block measures how many received bits differ from the bits that were sent over a link whose receive path has a fixed latency. Each sent bit enters a shift register, and one tap of that register supplies the reference. The tap is chosen by a delay setting, so the reference lines up in time with the received bit. The received bit is first caught in a single flip-flop clocked by the data clock. The reference and the retimed bit are then XORed. A high result counts as one error. Every compared pair also counts as one bit.

Software pulses start with a delay and a target bit total, waits for done, and reads the two counts. The error ratio is the error count divided by the bit count. Clear drops both counts and stops a measurement at any time. For the first delay-length clocks after start, no pair is compared, so the register can fill with fresh data before counting begins. When the target total is zero, the meter counts without a limit until it is cleared. In that mode the counters hold at all ones and never wrap.

Top module: `ber_meter`

## Requirements
- R1: After reset, `err_cnt_o` and `bit_cnt_o` are zero, `done_o` is low, and the meter is idle.
- R2: The reference is `tx_bit_i` delayed by D+1 clocks, where D is `delay_i` sampled with start. The received bit is delayed by one retiming flop. A link whose `rx_bit_i` equals `tx_bit_i` from D clocks earlier therefore yields zero errors, for any D from 0 to 63.
- R3: A compared pair whose XOR is 1 adds one to the error count. A pair whose XOR is 0 leaves the error count unchanged.
- R4: Every compared pair adds one to the bit count.
- R5: After start, the first D clocks compare nothing, and both counters hold at zero.
- R6: Start zeroes both counters and captures `delay_i` and `total_i`. A start while running or done begins a new measurement, and `done_o` drops on the next clock.
- R7: With a nonzero total, comparing stops once the bit count equals the total. `done_o` goes high on the following clock, and `done_o` and both counts hold until the next start or clear.
- R8: With a total of zero, comparing continues without limit and `done_o` stays low.
- R9: Both counters saturate at all ones and do not wrap.
- R10: Clear zeroes both counters and returns the meter to idle with `done_o` low on the next clock. When start and clear arrive in the same clock, clear wins.
- R11: While idle, the counters do not change, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; the retiming flop and the reference register both use it |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a measurement (one-clock pulse) |
| clear_i | input | 1 | Zero the counters and go idle (one-clock pulse) |
| tx_bit_i | input | 1 | Sent data bit |
| rx_bit_i | input | 1 | Received data bit |
| delay_i | input | DLY_W (6) | Link latency in clocks, 0 to MAX_DLY |
| total_i | input | CNT_W (32) | Number of bits to compare; zero means no limit |
| err_cnt_o | output | CNT_W (32) | Mismatch count |
| bit_cnt_o | output | CNT_W (32) | Compared bit count |
| done_o | output | 1 | Target total reached |

## Verification
Several functions can act in the same clock:

- **Start and clear together.** The bench drives both in one clock while the meter is done. It then checks that the counts are zero, that `done_o` is low, and that the meter stays idle afterwards rather than running.
- **Last error and the stop.** With the link fully inverted, the final comparison both adds an error and brings the bit count to the total. The bench judges this by the error count equalling the total, with done raised one clock later.
- **Fill window and delay setting.** A delay setting of 63, and one that differs from the real link latency, check that the fill window and the tap choice interact correctly.

A behavioural model in the bench checks all three counts against the design on every clock.

// File: rtl/ber_pkg.sv
package ber_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } meter_st_t;
endpackage

// File: rtl/ber_tap_delay.sv
// Reference shift register with a selectable tap (R2).
module ber_tap_delay #(
   parameter int MAX_DLY = 63,
   parameter int DLY_W   = $clog2(MAX_DLY + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_i,
   input  logic [DLY_W-1:0] tap_i,
   output logic             bit_o
);
   localparam int DEPTH = MAX_DLY + 1;

   if (MAX_DLY < 1) begin : g_bad_depth
      $error("ber_tap_delay: MAX_DLY must be at least 1");
   end

   logic [DEPTH-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= {sr_q[DEPTH-2:0], bit_i};
   end

   if ((1 << DLY_W) == DEPTH) begin : g_full_tap
      // Every tap code addresses a real stage.
      assign bit_o = sr_q[tap_i];
   end else begin : g_clamped_tap
      // Codes past the last stage read the last stage.
      logic [DLY_W-1:0] tap_c;
      assign tap_c = (tap_i > DLY_W'(MAX_DLY)) ? DLY_W'(MAX_DLY) : tap_i;
      assign bit_o = sr_q[tap_c];
   end
endmodule

// File: rtl/ber_sat_cnt.sv
// Saturating counter with synchronous clear (R4, R9).
module ber_sat_cnt #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] TOP = '1;

   if (CNT_W < 2) begin : g_bad_width
      $error("ber_sat_cnt: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (clr_i)                 cnt_q <= '0;
      else if (inc_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   // R9: a full counter stays full
   a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && inc_i && cnt_q == TOP) |=> cnt_q == TOP);

   // R4: one step per increment below the top
   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && inc_i && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/ber_seq.sv
// Measurement sequencer: start, fill window, stop at total, clear.
module ber_seq
   import ber_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int MAX_DLY = 63,
   parameter int DLY_W   = $clog2(MAX_DLY + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             clear_i,
   input  logic [DLY_W-1:0] delay_i,
   input  logic [CNT_W-1:0] total_i,
   input  logic [CNT_W-1:0] bit_cnt_i,
   output logic             cmp_en_o,
   output logic             cnt_clr_o,
   output logic [DLY_W-1:0] dly_o,
   output logic             done_o
);
   meter_st_t        st_q;
   logic [DLY_W-1:0] fill_q;
   logic [DLY_W-1:0] dly_q;
   logic [CNT_W-1:0] tot_q;
   logic [DLY_W-1:0] dly_ld;
   logic             limit_hit;

   always_comb begin
      dly_ld = (delay_i > DLY_W'(MAX_DLY)) ? DLY_W'(MAX_DLY) : delay_i;
   end

   assign limit_hit = (tot_q != '0) && (bit_cnt_i == tot_q);
   assign cnt_clr_o = start_i | clear_i;
   assign cmp_en_o  = (st_q == ST_RUN) && !cnt_clr_o && (fill_q == '0) && !limit_hit;
   assign dly_o     = dly_q;
   assign done_o    = (st_q == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         fill_q <= '0;
         dly_q  <= '0;
         tot_q  <= '0;
      end else if (clear_i) begin
         st_q   <= ST_IDLE;
         fill_q <= '0;
      end else if (start_i) begin
         st_q   <= ST_RUN;
         fill_q <= dly_ld;
         dly_q  <= dly_ld;
         tot_q  <= total_i;
      end else if (st_q == ST_RUN) begin
         if (fill_q != '0)   fill_q <= fill_q - 1'b1;
         else if (limit_hit) st_q   <= ST_DONE;
      end
   end

   // R5: while the fill window is open the bit count holds
   a_r5_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_q != '0 && !start_i && !clear_i) |=> bit_cnt_i == $past(bit_cnt_i));

   // R7: done persists and freezes the bit count
   a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DONE && !start_i && !clear_i) |=> (st_q == ST_DONE && bit_cnt_i == $past(bit_cnt_i)));

   // R6: start leads to running on the next clock
   a_r6_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !clear_i) |=> (st_q == ST_RUN && bit_cnt_i == '0));
endmodule

// File: rtl/ber_meter.sv
// Delay-aligned bit error meter top.
module ber_meter #(
   parameter int CNT_W   = 32,
   parameter int MAX_DLY = 63,
   parameter int DLY_W   = $clog2(MAX_DLY + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             clear_i,
   input  logic             tx_bit_i,
   input  logic             rx_bit_i,
   input  logic [DLY_W-1:0] delay_i,
   input  logic [CNT_W-1:0] total_i,
   output logic [CNT_W-1:0] err_cnt_o,
   output logic [CNT_W-1:0] bit_cnt_o,
   output logic             done_o
);
   if (DLY_W < $clog2(MAX_DLY + 1)) begin : g_bad_dly_w
      $error("ber_meter: DLY_W too narrow for MAX_DLY");
   end

   logic             rx_q;
   logic             ref_bit;
   logic             cmp_en;
   logic             cnt_clr;
   logic             mismatch;
   logic [DLY_W-1:0] dly_sel;

   // R2: received bit retimed on the data clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_q <= 1'b0;
      else        rx_q <= rx_bit_i;
   end

   ber_tap_delay #(.MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) u_ref (
      .clk   (clk),
      .rst_n (rst_n),
      .bit_i (tx_bit_i),
      .tap_i (dly_sel),
      .bit_o (ref_bit)
   );

   ber_seq #(.CNT_W(CNT_W), .MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .clear_i   (clear_i),
      .delay_i   (delay_i),
      .total_i   (total_i),
      .bit_cnt_i (bit_cnt_o),
      .cmp_en_o  (cmp_en),
      .cnt_clr_o (cnt_clr),
      .dly_o     (dly_sel),
      .done_o    (done_o)
   );

   // R3: XOR high marks one error
   assign mismatch = ref_bit ^ rx_q;

   ber_sat_cnt #(.CNT_W(CNT_W)) u_bits (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (cnt_clr),
      .inc_i (cmp_en),
      .cnt_o (bit_cnt_o)
   );

   ber_sat_cnt #(.CNT_W(CNT_W)) u_errs (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (cnt_clr),
      .inc_i (cmp_en & mismatch),
      .cnt_o (err_cnt_o)
   );

   // R3: errors never exceed compared bits
   a_r3_err_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      err_cnt_o <= bit_cnt_o);

   // R10: clear empties the counters and drops done
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (err_cnt_o == '0 && bit_cnt_o == '0 && !done_o));
endmodule

// File: tb/ber_meter_bench.sv
module ber_meter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CW         = 8;
   localparam int MAXD       = 63;
   localparam int DW         = 6;
   localparam int TOPV       = (1 << CW) - 1;
   localparam int WDOG       = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          clear = 1'b0;
   logic          tx = 1'b0;
   logic          rx = 1'b0;
   logic [DW-1:0] dly = '0;
   logic [CW-1:0] tot = '0;
   logic [CW-1:0] err_cnt;
   logic [CW-1:0] bit_cnt;
   logic          done;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ber_meter #(.CNT_W(CW), .MAX_DLY(MAXD), .DLY_W(DW)) u_ber_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .clear_i   (clear),
      .tx_bit_i  (tx),
      .rx_bit_i  (rx),
      .delay_i   (dly),
      .total_i   (tot),
      .err_cnt_o (err_cnt),
      .bit_cnt_o (bit_cnt),
      .done_o    (done)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   // link emulation
   int lat       = 0;
   bit inv_all   = 0;
   int flip_pct  = 0;
   bit txlog[$];

   // behavioural reference
   int m_state = 0;  // 0 idle, 1 run, 2 done
   int m_fill  = 0;
   int m_dly   = 0;
   int m_tot   = 0;
   int m_err   = 0;
   int m_bits  = 0;
   bit m_rxq   = 0;
   bit hist[$];

   always @(posedge clk) begin
      bit rf;
      bit cmp;
      if (!rst_n) begin
         m_state = 0; m_fill = 0; m_dly = 0; m_tot = 0;
         m_err = 0; m_bits = 0; m_rxq = 0;
         hist.delete();
         for (int i = 0; i <= MAXD; i++) hist.push_back(1'b0);
      end else begin
         rf  = hist[m_dly];
         cmp = 0;
         if (clear) begin
            m_state = 0; m_err = 0; m_bits = 0; m_fill = 0;
         end else if (start) begin
            m_state = 1; m_err = 0; m_bits = 0;
            m_fill = int'(dly); m_dly = int'(dly); m_tot = int'(tot);
         end else if (m_state == 1) begin
            if (m_fill > 0) m_fill--;
            else if (m_tot != 0 && m_bits == m_tot) m_state = 2;
            else cmp = 1;
         end
         if (cmp) begin
            if (m_bits < TOPV) m_bits++;
            if (rf != m_rxq && m_err < TOPV) m_err++;
         end
         m_rxq = rx;
         hist.push_front(tx);
         void'(hist.pop_back());
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one clock: compare at the falling edge, then drive new inputs
   task automatic tick(input bit s, input bit c);
      bit nb;
      @(negedge clk);
      if (rst_n) begin
         chk("R3 err count vs model", int'(err_cnt), m_err);
         chk("R4 bit count vs model", int'(bit_cnt), m_bits);
         chk("R7 done vs model", int'(done), (m_state == 2) ? 1 : 0);
      end
      start = s;
      clear = c;
      nb = 1'($urandom % 2);
      tx = nb;
      txlog.push_front(nb);
      if (txlog.size() > 128) void'(txlog.pop_back());
      nb = (txlog.size() > lat) ? txlog[lat] : 1'b0;
      if (inv_all) nb = ~nb;
      if (flip_pct > 0 && ($urandom % 100) < flip_pct) nb = ~nb;
      rx = nb;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) tick(0, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WDOG) begin
         n_chk++;
         n_bad++;
         $display("FAIL R7 watchdog actual=%0d expected=%0d", cyc, WDOG);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset err", int'(err_cnt), 0);
      chk("R1 reset bits", int'(bit_cnt), 0);
      chk("R1 reset done", int'(done), 0);

      // R11: idle ignores data
      flip_pct = 50;
      run(10);
      chk("R11 idle bits", int'(bit_cnt), 0);
      chk("R11 idle err", int'(err_cnt), 0);
      flip_pct = 0;

      // R2/R5/R7: matched delay 5, total 40
      lat = 5; dly = 6'd5; tot = 8'd40;
      run(8);
      tick(1, 0);
      run(3);
      chk("R5 fill window bits", int'(bit_cnt), 0);
      run(57);
      chk("R2 aligned zero errors", int'(err_cnt), 0);
      chk("R7 bits at total", int'(bit_cnt), 40);
      chk("R7 done raised", int'(done), 1);
      run(5);
      chk("R7 done holds", int'(done), 1);

      // R6: restart from done
      lat = 0; dly = 6'd0; tot = 8'd20; inv_all = 1;
      tick(1, 0);
      run(1);
      chk("R6 restart clears done", int'(done), 0);
      run(30);
      chk("R3 inverted link all errors", int'(err_cnt), 20);
      chk("R4 bits inverted run", int'(bit_cnt), 20);

      // R10: start and clear together
      tick(1, 1);
      run(1);
      chk("R10 clear wins bits", int'(bit_cnt), 0);
      chk("R10 clear wins done", int'(done), 0);
      run(6);
      chk("R11 idle after clear", int'(bit_cnt), 0);

      // R2: longest delay, random flips
      inv_all = 0; lat = 63; dly = 6'd63; tot = 8'd50; flip_pct = 10;
      run(70);
      tick(1, 0);
      run(130);
      chk("R7 long delay done", int'(done), 1);
      flip_pct = 0;

      // R2: mismatched delay setting yields errors per model
      lat = 7; dly = 6'd3; tot = 8'd60;
      run(10);
      tick(1, 0);
      run(80);

      // R10: clear mid-run
      lat = 2; dly = 6'd2; tot = 8'd100;
      tick(1, 0);
      run(20);
      tick(0, 1);
      run(2);
      chk("R10 mid-run clear bits", int'(bit_cnt), 0);
      chk("R10 mid-run clear err", int'(err_cnt), 0);

      // R8/R9: free run with saturation
      lat = 0; dly = 6'd0; tot = '0; inv_all = 1;
      tick(1, 0);
      run(300);
      chk("R9 bit count saturates", int'(bit_cnt), TOPV);
      chk("R9 err count saturates", int'(err_cnt), TOPV);
      chk("R8 no done in free run", int'(done), 0);
      run(3);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule